// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial bus in front of a 512-byte memory, held inside the block as a register array. It runs on a system clock and samples the bus clock and data lines through a short synchronizer. It answers on the data line only through an open-drain pull-down enable. The master addresses the memory with a header byte and a word byte, then writes single bytes or whole pages. After the stop that ends a write, the block stays deaf for a fixed number of system clocks, standing in for the self-timed programming cycle. This lets a master find the end of the cycle by polling for an acknowledge.

Reads come in three forms. A current-address read uses the internal pointer. A random read is preceded by a dummy write that loads that pointer. A sequential read goes on for as long as the master keeps acknowledging. An external protection block sees the target address of each data byte and grants or refuses that byte through a permit input. A second header type returns one byte from a control value supplied on an input.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset `sda_oe` is low. Bus activity that is not preceded by a start condition (SDA falling while SCL is high) never causes the block to pull SDA.
- R2: A header byte is acknowledged only when it reads 1010, 0, 0, A8, R/W from the first bit sent to the last, or 1011, 0, 0, x, 1 for a control read. Any other header gets no acknowledge, and the bytes that follow it are not acknowledged either, until the next start.
- R3: A write of header (R/W = 0), word byte and data byte, followed by a stop, stores the data at address {A8, word byte}. The word byte and the data byte are both acknowledged.
- R4: During a write, each accepted byte advances only the low four address bits, wrapping inside the 16-byte page. Bytes beyond sixteen overwrite earlier ones, and no location outside the page changes.
- R5: A stop that follows at least one accepted data byte starts a busy period of `WR_CYCLES` clocks. In that period start conditions and headers are ignored and get no acknowledge. After it ends, a header is acknowledged again.
- R6: A stop issued in the middle of the first data byte leaves memory unchanged and starts no busy period.
- R7: A read sends bytes MSB first and goes on while the master acknowledges. The pointer wraps from 1FFh to 000h. When the master does not acknowledge, the block releases SDA and ends the transfer.
- R8: A write header and word byte followed directly by a stop load the pointer without writing anything and without starting a busy period.
- R9: A data byte whose target address is refused by `wr_permit` is not acknowledged and is not stored. The block then ignores the bus until the next start.
- R10: Header 1011 with R/W = 1 returns `ctrl_data` as one byte, after which the block ignores the bus until the next start. Header 1011 with R/W = 0 is not acknowledged.
- R11: After any read or accepted write the pointer holds the last accessed address plus one. The A8 bit of a read header is ignored: a current-address read uses the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| wr_addr | output | 9 | Address the next data byte would be written to |
| wr_permit | input | 1 | High allows a write to `wr_addr` |
| ctrl_data | input | 8 | Byte returned by a control read |

## Verification
A wrong pointer inside the block shows up as a wrong byte on the very next read. That is why the bench follows every write with a read-back, and checks both the page-wrap and array-wrap boundaries as well as the pointer left behind after a page write. A stuck or miscounted busy flag shows up within one header byte, as a missing or unexpected acknowledge while polling. A bit counter or state that is off by one clock shows up on the same byte, either as shifted read data or as an acknowledge given on a refused header or byte.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int WR_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [8:0] wr_addr,
  input  logic       wr_permit,
  input  logic [7:0] ctrl_data
);
  localparam int BW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RDATA} st_t;

  st_t          state;
  logic [2:0]   scl_r, sda_r;
  logic [3:0]   bitcnt;
  logic [7:0]   sh;
  logic [8:0]   ptr;
  logic         hi, ctl, mack, wrote;
  logic [BW-1:0] bcnt;
  logic [7:0]   mem [512];

  logic scl, sda, st, sp, rise, fall, busy, act, mem_we, in_wr;
  logic arr_hit, ctl_hit;
  logic [7:0] src;

  assign scl  = scl_r[1];
  assign sda  = sda_r[1];
  assign st   = scl & scl_r[2] & sda_r[2] & ~sda;
  assign sp   = scl & scl_r[2] & ~sda_r[2] & sda;
  assign rise = scl & ~scl_r[2];
  assign fall = ~scl & scl_r[2];
  assign busy = bcnt != '0;
  assign act  = !sp && !(st && !busy) && state != S_IDLE;
  assign in_wr = state == S_WDATA;
  assign arr_hit = sh[7:2] == 6'b1010_00;
  assign ctl_hit = sh[7:2] == 6'b1011_00 && sh[0];
  assign src  = ctl ? ctrl_data : mem[ptr];
  assign wr_addr = ptr;
  assign mem_we = act && fall && in_wr && bitcnt == 4'd8 && wr_permit;

  always_ff @(posedge clk) if (mem_we) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= '1; sda_r <= '1; state <= S_IDLE; bitcnt <= '0; sh <= '0;
      ptr <= '0; hi <= 1'b0; ctl <= 1'b0; mack <= 1'b0; wrote <= 1'b0;
      bcnt <= '0; sda_oe <= 1'b0;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
      if (busy) bcnt <= bcnt - 1'b1;
      if (sp) begin
        state <= S_IDLE; sda_oe <= 1'b0; wrote <= 1'b0;
        if (wrote) bcnt <= BW'(WR_CYCLES);
      end else if (st && !busy) begin
        state <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0; ctl <= 1'b0; wrote <= 1'b0;
      end else if (act) begin
        if (rise) begin
          if (bitcnt < 4'd9) bitcnt <= bitcnt + 1'b1;
          if (state != S_RDATA && bitcnt < 4'd8) sh <= {sh[6:0], sda};
          if (state == S_RDATA && bitcnt == 4'd8) mack <= ~sda;
        end
        if (fall) begin
          if (state == S_RDATA) begin
            if (bitcnt inside {[4'd1:4'd7]}) sda_oe <= ~sh[3'd7 - bitcnt[2:0]];
            else if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              if (ctl) state <= S_IDLE;
              else ptr <= ptr + 1'b1;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (mack) begin sh <= src; sda_oe <= ~src[7]; end
              else state <= S_IDLE;
            end
          end else if (bitcnt == 4'd8) begin
            case (state)
              S_DEV:
                if (arr_hit) begin
                  sda_oe <= 1'b1; hi <= sh[1];
                  state <= sh[0] ? S_RDATA : S_ADDR;
                end else if (ctl_hit) begin
                  sda_oe <= 1'b1; ctl <= 1'b1; state <= S_RDATA;
                end else state <= S_IDLE;
              S_ADDR: begin
                sda_oe <= 1'b1; ptr <= {hi, sh}; state <= S_WDATA;
              end
              S_WDATA:
                if (wr_permit) begin
                  sda_oe <= 1'b1; wrote <= 1'b1;
                  ptr <= {ptr[8:4], ptr[3:0] + 4'd1};
                end else state <= S_IDLE;
              default: state <= S_IDLE;
            endcase
          end else if (bitcnt == 4'd9) begin
            sda_oe <= 1'b0; bitcnt <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       busy,
  input logic       sp,
  input logic       in_wr,
  input logic [8:0] ptr
);
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sp));

  p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_page_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && $past(in_wr)) |-> ptr[8:4] == $past(ptr[8:4]));
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl),
  .busy(busy), .sp(sp), .in_wr(in_wr), .ptr(ptr)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int CLK_P = 10;
  localparam int HP = 6;
  localparam int WRC = 600;
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {9'h005, 8'h5C}, {9'h006, 8'h6D}, {9'h030, 8'h3C},
    {9'h130, 8'hB7}, {9'h1FF, 8'hEE}, {9'h000, 8'h11}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, deny_en = 1'b0;
  logic sda_oe, wr_permit, sda_line;
  logic [8:0] wr_addr;
  int n_chk = 0, n_bad = 0;

  assign sda_line  = sda_m & ~sda_oe;
  assign wr_permit = !(deny_en && wr_addr[8]);
  always #(CLK_P/2) clk = ~clk;

  eeprom_i2c_slave #(.WR_CYCLES(WRC)) u_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_addr(wr_addr), .wr_permit(wr_permit), .ctrl_data(8'h5A)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hp(); repeat (HP) @(negedge clk); endtask
  task automatic i_start(); sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp(); endtask
  task automatic i_stop(); sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp(); hp(); endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    end
    sda_m = 1; hp(); scl_m = 1; hp(); ack = !sda_line; hp(); scl_m = 0; hp();
  endtask

  task automatic rx(input logic mack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1; hp(); d[i] = sda_line; hp(); scl_m = 0;
    end
    hp(); sda_m = !mack; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp(); sda_m = 1;
  endtask

  task automatic wr_byte(input logic [8:0] a, input logic [7:0] d, output logic ack);
    logic k;
    i_start(); tx({6'b1010_00, a[8], 1'b0}, k); tx(a[7:0], k); tx(d, ack); i_stop();
  endtask

  task automatic rd_rand(input logic [8:0] a, output logic [7:0] d);
    logic k;
    i_start(); tx({6'b1010_00, a[8], 1'b0}, k); tx(a[7:0], k);
    i_start(); tx(8'hA1, k); rx(1'b0, d); i_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic oe_seen;
    logic [7:0] d;
    logic [7:0] pg [16];
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", {8'h0, sda_oe}, 9'h0);

    oe_seen = 0;
    for (int i = 0; i < 18; i++) begin
      sda_m = i[1]; hp(); scl_m = 1; hp(); oe_seen |= sda_oe; scl_m = 0; hp(); oe_seen |= sda_oe;
    end
    sda_m = 1;
    chk("R1 no start no drive", {8'h0, oe_seen}, 9'h0);

    for (int v = 0; v < NV; v++) begin
      wr_byte(VEC[v][16:8], VEC[v][7:0], a);
      chk("R3 data ack", {8'h0, a}, 9'h1);
      repeat (WRC + 100) @(negedge clk);
      rd_rand(VEC[v][16:8], d);
      chk("R3 readback", {1'b0, d}, {1'b0, VEC[v][7:0]});
    end

    rd_rand(9'h005, d);
    i_start(); tx(8'hA1, a); rx(1'b0, d); i_stop();
    chk("R11 pointer plus one", {1'b0, d}, 9'h06D);

    i_start(); tx(8'hA0, a); tx(8'h30, a); i_stop();
    repeat (4) @(negedge clk);
    i_start(); tx(8'hA3, a);
    chk("R8 no busy after set address", {8'h0, a}, 9'h1);
    rx(1'b0, d); i_stop();
    chk("R8 R11 set address, read A8 ignored", {1'b0, d}, 9'h03C);

    i_start(); tx(8'hA4, a);
    chk("R2 bad zero bits nack", {8'h0, a}, 9'h0);
    tx(8'h05, a);
    chk("R2 ignored until start", {8'h0, a}, 9'h0);
    i_stop();
    i_start(); tx(8'hC0, a);
    chk("R2 bad type nack", {8'h0, a}, 9'h0);
    i_stop();

    i_start(); tx(8'hA0, a); tx(8'h05, a);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    end
    i_stop();
    i_start(); tx(8'hA0, a); i_stop();
    chk("R6 abort starts no busy", {8'h0, a}, 9'h1);
    rd_rand(9'h005, d);
    chk("R6 memory unchanged", {1'b0, d}, 9'h05C);

    i_start(); tx(8'hA0, a); tx(8'h2A, a);
    for (int i = 0; i < 18; i++) tx(8'h80 + 8'(i), a);
    i_stop();
    i_start(); tx(8'hA0, a); i_stop();
    chk("R5 polled while busy nack", {8'h0, a}, 9'h0);
    repeat (WRC + 100) @(negedge clk);
    i_start(); tx(8'hA0, a); i_stop();
    chk("R5 ack after busy", {8'h0, a}, 9'h1);
    i_start(); tx(8'hA1, a); rx(1'b0, d); i_stop();
    chk("R11 pointer after page write", {1'b0, d}, 9'h082);

    for (int i = 0; i < 16; i++) pg[i] = 8'h80 + 8'(((i - 10) & 15) + 0);
    pg[10] = 8'h90; pg[11] = 8'h91;
    i_start(); tx(8'hA0, a); tx(8'h20, a); i_start(); tx(8'hA1, a);
    for (int i = 0; i < 16; i++) begin
      rx(1'b1, d);
      chk("R4 page wrap content", {1'b0, d}, {1'b0, pg[i]});
    end
    rx(1'b0, d); i_stop();
    chk("R4 next page untouched", {1'b0, d}, 9'h03C);

    i_start(); tx(8'hA2, a); tx(8'hFF, a); i_start(); tx(8'hA1, a);
    rx(1'b1, d);
    chk("R7 top byte", {1'b0, d}, 9'h0EE);
    rx(1'b0, d);
    chk("R7 wrap to zero", {1'b0, d}, 9'h011);
    chk("R7 released after nack", {8'h0, sda_oe}, 9'h0);
    i_stop();

    deny_en = 1;
    i_start(); tx(8'hA2, a); tx(8'h30, a); tx(8'h99, a); i_stop();
    chk("R9 denied byte nack", {8'h0, a}, 9'h0);
    deny_en = 0;
    rd_rand(9'h130, d);
    chk("R9 denied byte not stored", {1'b0, d}, 9'h0B7);

    i_start(); tx(8'hB1, a);
    chk("R10 control read ack", {8'h0, a}, 9'h1);
    rx(1'b1, d);
    chk("R10 control byte", {1'b0, d}, 9'h05A);
    rx(1'b1, d);
    chk("R10 idle after one byte", {1'b0, d}, 9'h0FF);
    i_stop();
    i_start(); tx(8'hB0, a); i_stop();
    chk("R10 control write nack", {8'h0, a}, 9'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule